// File: doc/BRIEF.md
# Banked Register File with Operand Collector

This block holds the registers of one scheduler partition and gathers the source operands for instructions with up to three 32-bit sources. Storage is divided into four banks. The low two bits of a register's physical index select its bank, and each bank returns one word per cycle. The physical index is the per-warp base plus the architectural index, taken modulo 256.

An issue stage presents a request: a base, three source indices and a mask of the sources in use. The collector accepts the request, works out which sources compete for the same bank, and reads them over as many rounds as the worst bank needs. When every source has been read it presents all operands together and holds them under a valid flag until the consumer takes them. A separate write port updates one register per cycle, addressed by physical index.

Top module: `banked_rf_collector`

## Requirements
- R1: Physical register p lives in bank p mod 4 (the low 2 bits of p) at row p div 4.
- R2: A bank serves at most one distinct register per cycle. When all used sources fall in different banks, op_valid rises on the first clock edge after the edge that accepted the request.
- R3: Let N be the largest count of distinct physical registers that any one bank must deliver, or 1 if that count is lower. op_valid rises N edges after the accepting edge: 2 for one conflicting pair and 3 for three registers in the same bank.
- R4: A register named by more than one source is read once. Its value appears on each of those source slots and adds no cycle.
- R5: The physical index of each source is (req_base + index) mod 256. The returned data is the content of that physical register.
- R6: After reset req_ready is 1 and op_valid is 0. A request is accepted on an edge where req_valid and req_ready are both 1. req_ready then stays 0 until the edge where op_valid and op_ready are both 1, and it is 1 again after that edge.
- R7: While op_valid is 1 and op_ready is 0, op_valid stays 1 and op_data does not change. A request offered during that time has no effect.
- R8: A read round returns the value a register held before the clock edge that ends the round. A write committed on that same edge is not seen. A write committed on an earlier edge is seen.
- R9: A source whose bit in req_use is 0 returns zero on its op_data slot and takes no part in conflicts. With all bits 0, op_valid rises after one edge.
- R10: When wr_en is 1 on a clock edge, wr_data is stored in the register at physical index wr_idx. No base is added to wr_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the collector state |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Collector idle, request can be taken |
| req_base | input | 8 | Per-warp register base |
| req_idx | input | 3x8 | Architectural source indices, slot 0 to 2 |
| req_use | input | 3 | Bit s set when slot s is a real source |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 8 | Physical register to write |
| wr_data | input | 32 | Write data |
| op_valid | output | 1 | All operands gathered |
| op_ready | input | 1 | Consumer takes the operands |
| op_data | output | 3x32 | Operands, slot 0 to 2 |

## Verification
The hardest case to reach from the ports is a write that lands on a register during the same round in which the collector reads it. The request must be multi-round, and the write must be timed to the edge that closes one particular round. The bench sends three sources that share a bank, so there are three rounds in a known order. It writes the first source on the edge that ends round one, where the old value is expected. It writes the third source on the edge that ends round two, where the new value is expected. Duplicate indices, wrapping bases and masked slots that would otherwise conflict are each set up with their own hand-computed round counts.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    // Collector phases: waiting for a request, reading rounds, presenting operands
    typedef enum logic [1:0] {
        COL_IDLE   = 2'd0,
        COL_GATHER = 2'd1,
        COL_VALID  = 2'd2
    } col_state_e;

endpackage

// File: rtl/rfc_bank.sv
module rfc_bank #(
    parameter int ROW_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ROW_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROWS = 2 ** ROW_W;

    logic [DATA_W-1:0] mem_q [ROWS];

    // The read is combinational, so a write committed on the edge that ends
    // a round cannot reach that round's data.
    assign rdata = mem_q[raddr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/rfc_arbiter.sv
module rfc_arbiter #(
    parameter int NSRC   = 3,
    parameter int NBANK  = 4,
    parameter int IDX_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NSRC-1:0]                   pending,
    input  logic [NSRC-1:0][IDX_W-1:0]        idx,
    output logic [NBANK-1:0][IDX_W-$clog2(NBANK)-1:0] bank_row,
    output logic [NSRC-1:0]                   grant
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int ROW_W  = IDX_W - BANK_W;

    // Per bank, the leader is the lowest-numbered pending source mapped there.
    always_comb begin
        bank_row = '0;
        for (int b = 0; b < NBANK; b++) begin
            for (int t = NSRC - 1; t >= 0; t--) begin
                if (pending[t] && idx[t][BANK_W-1:0] == BANK_W'(b)) begin
                    bank_row[b] = idx[t][IDX_W-1:BANK_W];
                end
            end
        end
    end

    // Every pending source naming the leader's row rides along with it.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            grant[s] = pending[s] &&
                       (idx[s][IDX_W-1:BANK_W] == bank_row[idx[s][BANK_W-1:0]]);
        end
    end

    // R2: two sources granted together in one bank must name the same register
    for (genvar s = 0; s < NSRC; s++) begin : g_pair_a
        for (genvar t = s + 1; t < NSRC; t++) begin : g_pair_b
            p_one_read_per_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[s] && grant[t] && idx[s][BANK_W-1:0] == idx[t][BANK_W-1:0])
                |-> (idx[s] == idx[t]));
        end
    end

    // R3: any pending work makes progress each round
    p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|pending) |-> (|grant));

    // R3: a source is never granted unless still pending
    p_grant_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~pending) == '0));

    logic unused_row_w;
    assign unused_row_w = (ROW_W > 0);
endmodule

// File: rtl/banked_rf_collector.sv
module banked_rf_collector #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int NBANK  = 4,
    parameter int NSRC   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [IDX_W-1:0]            req_base,
    input  logic [NSRC-1:0][IDX_W-1:0]  req_idx,
    input  logic [NSRC-1:0]             req_use,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    output logic                        op_valid,
    input  logic                        op_ready,
    output logic [NSRC-1:0][DATA_W-1:0] op_data
);
    import rfc_pkg::*;

    localparam int BANK_W = $clog2(NBANK);
    localparam int ROW_W  = IDX_W - BANK_W;

    typedef struct packed {
        col_state_e                  state;
        logic [NSRC-1:0]             pending;
        logic [NSRC-1:0]             used;
        logic [NSRC-1:0][IDX_W-1:0]  pidx;
        logic [NSRC-1:0][DATA_W-1:0] data;
    } col_t;

    col_t col_d, col_q;

    logic [NBANK-1:0][ROW_W-1:0]  bank_row;
    logic [NBANK-1:0][DATA_W-1:0] bank_rdata;
    logic [NSRC-1:0]              grant;

    rfc_arbiter #(
        .NSRC  (NSRC),
        .NBANK (NBANK),
        .IDX_W (IDX_W)
    ) u_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (col_q.pending),
        .idx      (col_q.pidx),
        .bank_row (bank_row),
        .grant    (grant)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rfc_bank #(
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk   (clk),
            .we    (wr_en && (wr_idx[BANK_W-1:0] == BANK_W'(b))),
            .waddr (wr_idx[IDX_W-1:BANK_W]),
            .wdata (wr_data),
            .raddr (bank_row[b]),
            .rdata (bank_rdata[b])
        );
    end

    always_comb begin
        col_d = col_q;
        unique case (col_q.state)
            COL_IDLE: begin
                if (req_valid) begin
                    col_d.state   = COL_GATHER;
                    col_d.pending = req_use;
                    col_d.used    = req_use;
                    col_d.data    = '0;
                    for (int s = 0; s < NSRC; s++) begin
                        col_d.pidx[s] = req_idx[s] + req_base;
                    end
                end
            end
            COL_GATHER: begin
                for (int s = 0; s < NSRC; s++) begin
                    if (grant[s]) begin
                        col_d.data[s] = bank_rdata[col_q.pidx[s][BANK_W-1:0]];
                    end
                end
                col_d.pending = col_q.pending & ~grant;
                if (col_d.pending == '0) begin
                    col_d.state = COL_VALID;
                end
            end
            COL_VALID: begin
                if (op_ready) begin
                    col_d.state = COL_IDLE;
                end
            end
            default: col_d.state = COL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '{state: COL_IDLE, default: '0};
        end else begin
            col_q <= col_d;
        end
    end

    assign req_ready = (col_q.state == COL_IDLE);
    assign op_valid  = (col_q.state == COL_VALID);
    assign op_data   = col_q.data;

    // R6: an accepted request closes the request side on the next cycle
    p_accept_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6: a completed output handshake reopens the request side
    p_release_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> (req_ready && !op_valid));

    // R7: operands stay put while the consumer stalls
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_data)));

    // R9: masked slots present zero
    for (genvar s = 0; s < NSRC; s++) begin : g_unused_chk
        p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && !col_q.used[s]) |-> (op_data[s] == '0));
    end
endmodule

// File: tb/test_banked_rf_collector.sv
module test_banked_rf_collector;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [7:0]        req_base = '0;
    logic [2:0][7:0]   req_idx = '0;
    logic [2:0]        req_use = '0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_idx = '0;
    logic [31:0]       wr_data = '0;
    logic              op_valid;
    logic              op_ready = 1'b0;
    logic [2:0][31:0]  op_data;

    logic [31:0] model [256];
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    banked_rf_collector i_banked_rf_collector (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_idx(req_idx), .req_use(req_use),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .op_valid(op_valid), .op_ready(op_ready), .op_data(op_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] idx, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        @(posedge clk);
        model[idx] = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one request, measure rounds, compare data, optionally stall the consumer.
    task automatic run_op(input logic [7:0] base, input logic [7:0] i0,
                          input logic [7:0] i1, input logic [7:0] i2,
                          input logic [2:0] use_m, input int exp_n,
                          input int hold, input string tag);
        int lat = 0;
        logic [2:0][31:0] snap;
        @(negedge clk);
        chk(req_ready === 1'b1, "R6", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_base = base; req_use = use_m;
        req_idx[0] = i0; req_idx[1] = i1; req_idx[2] = i2;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready === 1'b0, "R6", "ready while busy", 32'(req_ready), 32'd0);
        for (int c = 1; c <= 8 && lat == 0; c++) begin
            @(posedge clk);
            #1;
            if (op_valid === 1'b1) lat = c;
        end
        chk(lat == exp_n, tag, "rounds to valid", 32'(lat), 32'(exp_n));
        for (int s = 0; s < 3; s++) begin
            logic [7:0] p = 8'(base + req_idx[s]);
            logic [31:0] e = use_m[s] ? model[p] : 32'd0;
            chk(op_data[s] === e, tag, $sformatf("slot %0d data", s), op_data[s], e);
        end
        snap = op_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            // offered request must be ignored while operands are held
            req_valid = 1'b1; req_idx[0] = 8'd3; req_use = 3'b001;
            @(posedge clk);
            #1;
            chk(op_valid === 1'b1 && op_data === snap, "R7", "held operands",
                op_data[0], snap[0]);
            chk(req_ready === 1'b0, "R7", "ready during hold", 32'(req_ready), 32'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        op_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_ready = 1'b0;
        chk(op_valid === 1'b0 && req_ready === 1'b1, "R6", "after handshake",
            {30'd0, op_valid, req_ready}, 32'd1);
    endtask

    // Three sources in bank 0; writes land on the edges closing rounds 1 and 2.
    task automatic run_rbw();
        int lat = 0;
        logic [31:0] old0 = model[0];
        logic [31:0] v4   = model[4];
        logic [31:0] new0 = 32'hDEAD_0000;
        logic [31:0] new8 = 32'hBEEF_0008;
        @(negedge clk);
        req_valid = 1'b1; req_base = 8'd0; req_use = 3'b111;
        req_idx[0] = 8'd0; req_idx[1] = 8'd4; req_idx[2] = 8'd8;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_idx = 8'd0; wr_data = new0;
        @(posedge clk);
        model[0] = new0;
        @(negedge clk);
        wr_idx = 8'd8; wr_data = new8;
        @(posedge clk);
        model[8] = new8;
        @(negedge clk);
        wr_en = 1'b0;
        lat = 2;
        for (int c = 3; c <= 8 && lat == 2; c++) begin
            @(posedge clk);
            #1;
            if (op_valid === 1'b1) lat = c;
        end
        chk(lat == 3, "R3", "rbw rounds", 32'(lat), 32'd3);
        chk(op_data[0] === old0, "R8", "same-edge write unseen", op_data[0], old0);
        chk(op_data[1] === v4, "R8", "untouched source", op_data[1], v4);
        chk(op_data[2] === new8, "R8", "earlier write seen", op_data[2], new8);
        @(negedge clk);
        op_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_ready = 1'b0;
        run_op(8'd0, 8'd0, 8'd8, 8'd1, 3'b111, 2, 0, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready === 1'b1, "R6", "reset ready", 32'(req_ready), 32'd1);
        chk(op_valid === 1'b0, "R6", "reset valid", 32'(op_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) begin
            write_reg(8'(i), (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000);
        end
        // R1 R2: banks 1,2,3 distinct
        run_op(8'd0, 8'd1, 8'd2, 8'd3, 3'b111, 1, 0, "R2");
        // R3: all in bank 0
        run_op(8'd0, 8'd0, 8'd4, 8'd8, 3'b111, 3, 0, "R3");
        // R1: pair in bank 0 plus bank 1
        run_op(8'd0, 8'd0, 8'd4, 8'd1, 3'b111, 2, 0, "R1");
        // R4: duplicate 5 plus 9 in bank 1
        run_op(8'd0, 8'd5, 8'd5, 8'd9, 3'b111, 2, 0, "R4");
        run_op(8'd0, 8'd7, 8'd7, 8'd7, 3'b111, 1, 0, "R4");
        // R5: base offsets, including wrap to 0,4,8
        run_op(8'd3, 8'd1, 8'd2, 8'd3, 3'b111, 1, 0, "R5");
        run_op(8'd1, 8'd0, 8'd4, 8'd8, 3'b111, 3, 0, "R5");
        run_op(8'd250, 8'd6, 8'd10, 8'd14, 3'b111, 3, 0, "R5");
        // R9: masked slot would conflict; none used
        run_op(8'd0, 8'd0, 8'd4, 8'd2, 3'b101, 1, 0, "R9");
        run_op(8'd0, 8'd0, 8'd4, 8'd8, 3'b000, 1, 0, "R9");
        // R7: consumer stall
        run_op(8'd0, 8'd12, 8'd13, 8'd16, 3'b111, 2, 4, "R7");
        // R8 R10
        run_rbw();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule